// File: doc/BRIEF.md
# SECDED Memory Guard with Error Injection

This block sits between a simple single-port write/read interface and an internal RAM that keeps each 64-bit data word alongside 8 check bits. Every write is encoded with a Hamming code extended by an overall parity bit. Every read is decoded: one flipped bit is repaired before the data is returned, and two flipped bits are reported without repair. Three or more flipped bits are not guaranteed to be seen.

To test error handling, software can arm an injection mode. While it is armed, each write stores the data XORed with a 64-bit data mask, split into low and high 32-bit registers, and stores the check bits XORed with an 8-bit check mask. The check bits are always computed from the clean data, so the stored word holds a genuine fault. That fault comes back on every read of the address until the address is written again with injection off. Corrected reads drive a saturating counter. A sticky single-error flag is raised when the counter reaches a programmable threshold. A double error raises its own sticky flag. The first faulty read after a status clear records its address and syndrome. An interrupt is formed from the flags and their enables.

Top module: `ecc_inject_ctrl`

## Requirements
- R1: A word written with injection off is read back unchanged, and the counter and both flags stay unchanged.
- R2: A read that finds exactly one flipped data bit returns the corrected word and adds one to the error counter (register 5).
- R3: The single-error flag (status bit 0, register 4) is set only by a corrected read that brings the counter to a value equal to the threshold (register 6, reset value 1). A threshold of 0 never sets it.
- R4: A read that finds two flipped bits sets the double-error flag (status bit 1), returns the stored word without correction, and leaves the counter unchanged.
- R5: The check-bit mask (register 3, bits 7:0) is XORed into the stored check bits during injection. One flipped check bit is a corrected single error, and the data comes back intact.
- R6: An injected fault stays in memory after injection is disabled (control bit 0, register 0) and recurs on every read, until a write with injection off stores clean data.
- R7: Writing a 1 to a status bit clears that flag. Writing a 0 leaves it as it is. Flags otherwise stay set.
- R8: The first faulty read after a status write is recorded in register 7: bit 31 valid, bits 23:16 syndrome, low bits the read address. The syndrome's bit 7 is the overall-parity mismatch and bits 6:0 the Hamming syndrome. Data bit i sits at the (i+1)-th codeword position that is not a power of two, so data bit 0 is at position 3 and data bit 1 at position 5. Later faults leave the record unchanged, and any status write clears the valid bit.
- R9: The interrupt equals (single flag AND control bit 1) OR (double flag AND control bit 2). It stays high until the flags are cleared.
- R10: Any write to the counter register resets it to 0. The counter stops at its all-ones value instead of wrapping.
- R11: Read data and a one-cycle read-valid pulse appear two clock edges after the edge that accepts a read request.
- R12: After reset, all control and mask registers are 0, the flags and the counter are 0, the threshold is 1, and the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_req | input | 1 | Memory access request |
| mem_we | input | 1 | 1 for write, 0 for read |
| mem_addr | input | ADDR_W | Word address |
| mem_wdata | input | 64 | Write data |
| mem_rvalid | output | 1 | Read data valid pulse |
| mem_rdata | output | 64 | Read data, corrected when possible |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after address |
| irq | output | 1 | Error interrupt |

## Verification
A table of words paired with injection masks covers several cases: clean words, single flips at the lowest and highest data bits and at a middle bit, and double flips in adjacent and in distant bits. These cases separate correction from detection and show whether the counter moves only on correctable faults. Directed cases cover the following: a threshold of 2, where only the second corrected read raises the flag; a single check-bit flip, which must not disturb the data; repeated reads of a faulty word before and after a clean rewrite; a first-fault record that must hold when a second fault arrives; and W1C writes that clear one flag but leave the other set. Counter saturation is reached by driving more corrected reads than the counter can hold.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  localparam int DW = 64;
  localparam int HW = 7;
  localparam int CW = HW + 1;
  localparam int RW = 32;
  localparam int RA_W = 3;

  localparam logic [RA_W-1:0] RG_CTRL   = 3'd0;
  localparam logic [RA_W-1:0] RG_MLO    = 3'd1;
  localparam logic [RA_W-1:0] RG_MHI    = 3'd2;
  localparam logic [RA_W-1:0] RG_MCHK   = 3'd3;
  localparam logic [RA_W-1:0] RG_STAT   = 3'd4;
  localparam logic [RA_W-1:0] RG_COUNT  = 3'd5;
  localparam logic [RA_W-1:0] RG_THRESH = 3'd6;
  localparam logic [RA_W-1:0] RG_CAPT   = 3'd7;

  typedef logic [HW-1:0] pos_t;
  typedef pos_t [DW-1:0] pos_tab_t;

  // Codeword position of each data bit: positions that are not powers of two
  function automatic pos_tab_t build_pos_tab();
    pos_tab_t t;
    int n;
    t = '0;
    n = 0;
    for (int p = 1; p < (1 << HW); p++) begin
      if ((p & (p - 1)) != 0) begin
        if (n < DW) t[n] = pos_t'(p);
        n++;
      end
    end
    return t;
  endfunction

  localparam pos_tab_t POS_TAB = build_pos_tab();

  function automatic logic [HW-1:0] ham_bits(logic [DW-1:0] d);
    logic [HW-1:0] h;
    h = '0;
    for (int i = 0; i < DW; i++) begin
      for (int k = 0; k < HW; k++) begin
        if (POS_TAB[i][k]) h[k] = h[k] ^ d[i];
      end
    end
    return h;
  endfunction

  // Check bits: [HW-1:0] Hamming, [HW] overall parity (even over the word)
  function automatic logic [CW-1:0] ecc_encode(logic [DW-1:0] d);
    logic [HW-1:0] h;
    h = ham_bits(d);
    return {(^d) ^ (^h), h};
  endfunction
endpackage

// File: rtl/ecc_wr_path.sv
module ecc_wr_path
  import ecc_pkg::*;
(
  input  logic [DW-1:0] wdata,
  input  logic          inj_en,
  input  logic [DW-1:0] data_mask,
  input  logic [CW-1:0] chk_mask,
  output logic [DW-1:0] st_data,
  output logic [CW-1:0] st_chk
);
  logic [CW-1:0] clean_chk;

  always_comb begin
    clean_chk = ecc_encode(wdata);
    if (inj_en) begin
      st_data = wdata ^ data_mask;
      st_chk  = clean_chk ^ chk_mask;
    end else begin
      st_data = wdata;
      st_chk  = clean_chk;
    end
  end
endmodule

// File: rtl/ecc_rd_path.sv
module ecc_rd_path
  import ecc_pkg::*;
(
  input  logic [DW-1:0] rd_data,
  input  logic [CW-1:0] rd_chk,
  output logic [DW-1:0] fix_data,
  output logic [CW-1:0] syndrome,
  output logic          err_single,
  output logic          err_double
);
  logic [HW-1:0] syn_h;
  logic          par_miss;

  always_comb begin
    syn_h    = ham_bits(rd_data) ^ rd_chk[HW-1:0];
    par_miss = (^rd_data) ^ (^rd_chk);
    fix_data = rd_data;
    if (par_miss) begin
      for (int i = 0; i < DW; i++) begin
        if (POS_TAB[i] == syn_h) fix_data[i] = ~rd_data[i];
      end
    end
    syndrome   = {par_miss, syn_h};
    err_single = par_miss;
    err_double = !par_miss && (syn_h != '0);
  end
endmodule

// File: rtl/ecc_store.sv
module ecc_store #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 72
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wr_word,
  output logic [WORD_W-1:0] rd_word
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) ram[addr] <= wr_word;
    if (rd_en) rd_word <= ram[addr];
  end
endmodule

// File: rtl/ecc_csr.sv
module ecc_csr
  import ecc_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [RW-1:0]     reg_wdata,
  output logic [RW-1:0]     reg_rdata,
  input  logic              ev_valid,
  input  logic              ev_single,
  input  logic              ev_double,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic [CW-1:0]     ev_syn,
  output logic              inj_en,
  output logic [DW-1:0]     data_mask,
  output logic [CW-1:0]     chk_mask,
  output logic              en_sbe,
  output logic              en_mbe,
  output logic              flag_sbe,
  output logic              flag_mbe,
  output logic [CNT_W-1:0]  err_cnt,
  output logic              cap_valid,
  output logic [CW-1:0]     cap_syn,
  output logic [ADDR_W-1:0] cap_addr,
  output logic              irq
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam int CTRL_W = 3;
  localparam int CAP_AW = 16;

  logic [CTRL_W-1:0] ctrl_q, ctrl_n;
  logic [RW-1:0]     mlo_q, mhi_q;
  logic [CW-1:0]     mchk_q;
  logic [CNT_W-1:0]  cnt_q, cnt_n, thr_q;
  logic              sbe_q, sbe_n, mbe_q, mbe_n;
  logic              capv_q, capv_n;
  logic [CW-1:0]     csyn_q;
  logic [ADDR_W-1:0] caddr_q;
  logic              irq_q;
  logic              wr_stat, wr_cnt, do_cap, inc;

  assign wr_stat = reg_wr && (reg_addr == RG_STAT);
  assign wr_cnt  = reg_wr && (reg_addr == RG_COUNT);
  assign inc     = ev_valid && ev_single;
  assign do_cap  = ev_valid && (ev_single || ev_double) && !capv_q;

  always_comb begin
    ctrl_n = ctrl_q;
    if (reg_wr && reg_addr == RG_CTRL) ctrl_n = reg_wdata[CTRL_W-1:0];

    sbe_n = sbe_q;
    mbe_n = mbe_q;
    if (wr_stat) begin
      sbe_n = sbe_q & ~reg_wdata[0];
      mbe_n = mbe_q & ~reg_wdata[1];
    end

    cnt_n = cnt_q;
    if (inc && cnt_q != CNT_MAX) cnt_n = cnt_q + 1'b1;
    if (inc && cnt_n == thr_q) sbe_n = 1'b1;
    if (wr_cnt) cnt_n = '0;
    if (ev_valid && ev_double) mbe_n = 1'b1;

    capv_n = capv_q;
    if (wr_stat) capv_n = 1'b0;
    if (do_cap) capv_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      mlo_q   <= '0;
      mhi_q   <= '0;
      mchk_q  <= '0;
      thr_q   <= CNT_W'(1);
      cnt_q   <= '0;
      sbe_q   <= 1'b0;
      mbe_q   <= 1'b0;
      capv_q  <= 1'b0;
      csyn_q  <= '0;
      caddr_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      ctrl_q <= ctrl_n;
      if (reg_wr && reg_addr == RG_MLO)    mlo_q  <= reg_wdata;
      if (reg_wr && reg_addr == RG_MHI)    mhi_q  <= reg_wdata;
      if (reg_wr && reg_addr == RG_MCHK)   mchk_q <= reg_wdata[CW-1:0];
      if (reg_wr && reg_addr == RG_THRESH) thr_q  <= reg_wdata[CNT_W-1:0];
      cnt_q  <= cnt_n;
      sbe_q  <= sbe_n;
      mbe_q  <= mbe_n;
      capv_q <= capv_n;
      if (do_cap) begin
        csyn_q  <= ev_syn;
        caddr_q <= ev_addr;
      end
      irq_q <= (sbe_n && ctrl_n[1]) || (mbe_n && ctrl_n[2]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      unique case (reg_addr)
        RG_CTRL:   reg_rdata <= {{(RW-CTRL_W){1'b0}}, ctrl_q};
        RG_MLO:    reg_rdata <= mlo_q;
        RG_MHI:    reg_rdata <= mhi_q;
        RG_MCHK:   reg_rdata <= {{(RW-CW){1'b0}}, mchk_q};
        RG_STAT:   reg_rdata <= {{(RW-2){1'b0}}, mbe_q, sbe_q};
        RG_COUNT:  reg_rdata <= {{(RW-CNT_W){1'b0}}, cnt_q};
        RG_THRESH: reg_rdata <= {{(RW-CNT_W){1'b0}}, thr_q};
        RG_CAPT:   reg_rdata <= {capv_q, {(RW-1-CW-CAP_AW){1'b0}}, csyn_q,
                                 {(CAP_AW-ADDR_W){1'b0}}, caddr_q};
        default:   reg_rdata <= '0;
      endcase
    end
  end

  assign inj_en    = ctrl_q[0];
  assign en_sbe    = ctrl_q[1];
  assign en_mbe    = ctrl_q[2];
  assign data_mask = {mhi_q, mlo_q};
  assign chk_mask  = mchk_q;
  assign flag_sbe  = sbe_q;
  assign flag_mbe  = mbe_q;
  assign err_cnt   = cnt_q;
  assign cap_valid = capv_q;
  assign cap_syn   = csyn_q;
  assign cap_addr  = caddr_q;
  assign irq       = irq_q;
endmodule

// File: rtl/ecc_inject_ctrl.sv
module ecc_inject_ctrl
  import ecc_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mem_req,
  input  logic              mem_we,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [DW-1:0]     mem_wdata,
  output logic              mem_rvalid,
  output logic [DW-1:0]     mem_rdata,
  input  logic              reg_wr,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [RW-1:0]     reg_wdata,
  output logic [RW-1:0]     reg_rdata,
  output logic              irq
);
  localparam int WORD_W = DW + CW;

  logic              inj_en, en_sbe, en_mbe, flag_sbe, flag_mbe, cap_valid;
  logic [DW-1:0]     data_mask, st_data, fix_data;
  logic [CW-1:0]     chk_mask, st_chk, syndrome, cap_syn;
  logic [CNT_W-1:0]  err_cnt;
  logic [ADDR_W-1:0] cap_addr;
  logic [WORD_W-1:0] rd_word;
  logic              err_single, err_double;
  logic              rd_pend_q;
  logic [ADDR_W-1:0] rd_addr_q;

  ecc_wr_path u_wr (
    .wdata     (mem_wdata),
    .inj_en    (inj_en),
    .data_mask (data_mask),
    .chk_mask  (chk_mask),
    .st_data   (st_data),
    .st_chk    (st_chk)
  );

  ecc_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_store (
    .clk     (clk),
    .wr_en   (mem_req && mem_we),
    .rd_en   (mem_req && !mem_we),
    .addr    (mem_addr),
    .wr_word ({st_chk, st_data}),
    .rd_word (rd_word)
  );

  ecc_rd_path u_rd (
    .rd_data    (rd_word[DW-1:0]),
    .rd_chk     (rd_word[WORD_W-1:DW]),
    .fix_data   (fix_data),
    .syndrome   (syndrome),
    .err_single (err_single),
    .err_double (err_double)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend_q  <= 1'b0;
      rd_addr_q  <= '0;
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
    end else begin
      rd_pend_q  <= mem_req && !mem_we;
      if (mem_req && !mem_we) rd_addr_q <= mem_addr;
      mem_rvalid <= rd_pend_q;
      if (rd_pend_q) mem_rdata <= fix_data;
    end
  end

  ecc_csr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_csr (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ev_valid  (rd_pend_q),
    .ev_single (err_single),
    .ev_double (err_double),
    .ev_addr   (rd_addr_q),
    .ev_syn    (syndrome),
    .inj_en    (inj_en),
    .data_mask (data_mask),
    .chk_mask  (chk_mask),
    .en_sbe    (en_sbe),
    .en_mbe    (en_mbe),
    .flag_sbe  (flag_sbe),
    .flag_mbe  (flag_mbe),
    .err_cnt   (err_cnt),
    .cap_valid (cap_valid),
    .cap_syn   (cap_syn),
    .cap_addr  (cap_addr),
    .irq       (irq)
  );
endmodule

// File: rtl/ecc_inject_ctrl_chk.sv
module ecc_inject_ctrl_chk
  import ecc_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_rvalid,
  input logic              reg_wr,
  input logic [RA_W-1:0]   reg_addr,
  input logic [1:0]        clr_bits,
  input logic              irq,
  input logic              en_sbe,
  input logic              en_mbe,
  input logic              flag_sbe,
  input logic              flag_mbe,
  input logic [CNT_W-1:0]  err_cnt,
  input logic              cap_valid,
  input logic [CW-1:0]     cap_syn,
  input logic [ADDR_W-1:0] cap_addr
);
  logic [1:0] since_rst;
  logic       wr_stat, wr_cnt;

  assign wr_stat = reg_wr && (reg_addr == RG_STAT);
  assign wr_cnt  = reg_wr && (reg_addr == RG_COUNT);

  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 1'b1;
  end

  assert_read_latency_R11: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2) |-> (mem_rvalid == $past(mem_req && !mem_we, 2)));

  assert_sbe_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (flag_sbe && !(wr_stat && clr_bits[0])) |=> flag_sbe);

  assert_mbe_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (flag_mbe && !(wr_stat && clr_bits[1])) |=> flag_mbe);

  assert_irq_sources_R9: assert property (@(posedge clk) disable iff (rst)
    irq == ((flag_sbe && en_sbe) || (flag_mbe && en_mbe)));

  assert_no_wrap_R10: assert property (@(posedge clk) disable iff (rst)
    !wr_cnt |=> (err_cnt >= $past(err_cnt)));

  assert_single_step_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ({1'b0, err_cnt} <= ({1'b0, $past(err_cnt)} + 1'b1)));

  assert_capture_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (cap_valid && !wr_stat) |=> (cap_valid && $stable(cap_syn) && $stable(cap_addr)));
endmodule

bind ecc_inject_ctrl ecc_inject_ctrl_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_rvalid (mem_rvalid),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .clr_bits   (reg_wdata[1:0]),
  .irq        (irq),
  .en_sbe     (en_sbe),
  .en_mbe     (en_mbe),
  .flag_sbe   (flag_sbe),
  .flag_mbe   (flag_mbe),
  .err_cnt    (err_cnt),
  .cap_valid  (cap_valid),
  .cap_syn    (cap_syn),
  .cap_addr   (cap_addr)
);

// File: tb/ecc_inject_ctrl_tb.sv
module ecc_inject_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 6;
  localparam int CNT_W  = 8;
  localparam int NV = 6;

  localparam logic [63:0] V_DATA [NV] = '{
    64'h0123456789ABCDEF, 64'hAAAAAAAAAAAAAAAA, 64'h0000000000000000,
    64'hFFFFFFFFFFFFFFFF, 64'h5555555555555555, 64'hDEADBEEF00C0FFEE};
  localparam logic [63:0] V_MASK [NV] = '{
    64'h0, 64'h1, 64'h8000000000000000,
    64'h3, 64'h0000010000000000, 64'h0000000000100400};
  localparam logic [63:0] V_EXP  [NV] = '{
    64'h0123456789ABCDEF, 64'hAAAAAAAAAAAAAAAA, 64'h0000000000000000,
    64'hFFFFFFFFFFFFFFFC, 64'h5555555555555555, 64'hDEADBEEF00D0FBEE};
  localparam logic [NV-1:0] V_SGL = 6'b010110;
  localparam logic [NV-1:0] V_DBL = 6'b101000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              mem_req = 1'b0, mem_we = 1'b0;
  logic [ADDR_W-1:0] mem_addr = '0;
  logic [63:0]       mem_wdata = '0;
  logic              mem_rvalid;
  logic [63:0]       mem_rdata;
  logic              reg_wr = 1'b0;
  logic [2:0]        reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic              irq;

  int checks = 0;
  int fails  = 0;

  ecc_inject_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic mem_write(input logic [ADDR_W-1:0] a, input logic [63:0] d);
    @(negedge clk);
    mem_req = 1'b1; mem_we = 1'b1; mem_addr = a; mem_wdata = d;
    @(negedge clk);
    mem_req = 1'b0; mem_we = 1'b0;
  endtask

  task automatic mem_read(input logic [ADDR_W-1:0] a, output logic [63:0] d,
                          output logic v);
    @(negedge clk);
    mem_req = 1'b1; mem_we = 1'b0; mem_addr = a;
    @(negedge clk);
    mem_req = 1'b0;
    @(negedge clk);
    d = mem_rdata; v = mem_rvalid;
  endtask

  task automatic inject_write(input logic [ADDR_W-1:0] a, input logic [63:0] d,
                              input logic [63:0] m, input logic [7:0] cm);
    reg_write(3'd1, m[31:0]);
    reg_write(3'd2, m[63:32]);
    reg_write(3'd3, {24'h0, cm});
    reg_write(3'd0, 32'h1);
    mem_write(a, d);
    reg_write(3'd0, 32'h0);
  endtask

  task automatic clear_all();
    reg_write(3'd4, 32'h3);
    reg_write(3'd5, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [63:0] d;
    logic        v;

    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R12 reset state
    check(irq == 1'b0 && mem_rvalid == 1'b0, "R12 irq/rvalid", {irq, mem_rvalid}, 0);
    for (int a = 0; a < 8; a++) begin
      reg_read(3'(a), r);
      check(r == ((a == 6) ? 32'h1 : 32'h0), $sformatf("R12 reg%0d", a), r,
            (a == 6) ? 64'h1 : 64'h0);
    end

    // R11 latency: pulse two edges after accepting edge
    mem_write(6'd1, 64'h1111);
    @(negedge clk);
    mem_req = 1'b1; mem_we = 1'b0; mem_addr = 6'd1;
    @(negedge clk);
    mem_req = 1'b0;
    check(mem_rvalid == 1'b0, "R11 no early valid", mem_rvalid, 0);
    @(negedge clk);
    check(mem_rvalid == 1'b1 && mem_rdata == 64'h1111, "R11 valid data", mem_rdata, 64'h1111);
    @(negedge clk);
    check(mem_rvalid == 1'b0, "R11 one-cycle pulse", mem_rvalid, 0);

    // Vector table: R1 clean, R2 single, R4 double
    for (int i = 0; i < NV; i++) begin
      inject_write(6'(20 + i), V_DATA[i], V_MASK[i], 8'h0);
      clear_all();
      mem_read(6'(20 + i), d, v);
      check(v && d == V_EXP[i], $sformatf("R1/R2/R4 vec%0d data", i), d, V_EXP[i]);
      reg_read(3'd5, r);
      check(r == {31'h0, V_SGL[i]}, $sformatf("R2/R4 vec%0d count", i), r, V_SGL[i]);
      reg_read(3'd4, r);
      check(r == {30'h0, V_DBL[i], V_SGL[i]}, $sformatf("R1/R4 vec%0d status", i),
            r, {V_DBL[i], V_SGL[i]});
    end

    // R3 threshold 2, R6 persistence
    reg_write(3'd6, 32'd2);
    inject_write(6'd10, 64'hCAFE, 64'h4, 8'h0);
    clear_all();
    mem_read(6'd10, d, v);
    reg_read(3'd4, r);
    check(r[0] == 1'b0, "R3 below threshold", r, 0);
    mem_read(6'd10, d, v);
    check(d == 64'hCAFE, "R6 repeat read corrected", d, 64'hCAFE);
    reg_read(3'd5, r);
    check(r == 32'd2, "R6 fault recurs count", r, 2);
    reg_read(3'd4, r);
    check(r[0] == 1'b1, "R3 flag at threshold", r, 1);
    mem_write(6'd10, 64'hCAFE);
    reg_write(3'd5, 32'h0);
    mem_read(6'd10, d, v);
    reg_read(3'd5, r);
    check(r == 32'd0 && d == 64'hCAFE, "R6 rewrite stops errors", r, 0);
    reg_write(3'd6, 32'd1);

    // R5 check-bit injection
    inject_write(6'd11, 64'h0F0F_0F0F_0F0F_0F0F, 64'h0, 8'h04);
    clear_all();
    mem_read(6'd11, d, v);
    check(d == 64'h0F0F_0F0F_0F0F_0F0F, "R5 data intact", d, 64'h0F0F_0F0F_0F0F_0F0F);
    reg_read(3'd5, r);
    check(r == 32'd1, "R5 counted as single", r, 1);
    reg_read(3'd7, r);
    check(r == 32'h8084_000B, "R8 check-bit syndrome", r, 64'h8084_000B);

    // R8 capture first fault, hold on second
    inject_write(6'd12, 64'h77, 64'h1, 8'h0);
    inject_write(6'd13, 64'h88, 64'h3, 8'h0);
    clear_all();
    mem_read(6'd12, d, v);
    mem_read(6'd13, d, v);
    reg_read(3'd7, r);
    check(r == 32'h8083_000C, "R8 first fault held", r, 64'h8083_000C);
    reg_write(3'd4, 32'h0);
    reg_read(3'd7, r);
    check(r[31] == 1'b0, "R8 status write clears valid", r, 0);
    reg_read(3'd4, r);
    check(r == 32'h3, "R7 zero write keeps flags", r, 3);

    // R9 interrupt and R7 per-bit clear
    clear_all();
    reg_write(3'd0, 32'h2);
    check(irq == 1'b0, "R9 idle irq", irq, 0);
    mem_read(6'd12, d, v);
    check(irq == 1'b1, "R9 irq on single", irq, 1);
    mem_read(6'd13, d, v);
    reg_write(3'd4, 32'h2);
    reg_read(3'd4, r);
    check(r == 32'h1 && irq == 1'b1, "R7 clear one flag only", r, 1);
    reg_write(3'd4, 32'h1);
    check(irq == 1'b0, "R9 irq drops on clear", irq, 0);
    reg_write(3'd0, 32'h4);
    mem_read(6'd13, d, v);
    check(irq == 1'b1, "R9 irq on double", irq, 1);
    reg_write(3'd0, 32'h0);

    // R10 saturation, threshold 0 never flags, counter write reset
    clear_all();
    reg_write(3'd6, 32'd0);
    for (int n = 0; n < 260; n++) mem_read(6'd12, d, v);
    reg_read(3'd5, r);
    check(r == 32'd255, "R10 saturates", r, 255);
    reg_read(3'd4, r);
    check(r[0] == 1'b0, "R3 threshold zero never sets", r, 0);
    reg_write(3'd5, 32'h5A);
    reg_read(3'd5, r);
    check(r == 32'd0, "R10 write resets", r, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule